// File: doc/BRIEF.md
# Match-Driven Multi-Channel PWM Timer

This block is a free-running timer with seven compare slots and six PWM outputs. A prescaler divides the peripheral clock into counter ticks. On each tick the counter is compared against every active compare value. Slot 0 always folds the counter back to zero, so it fixes one common period for all outputs. The other six slots place output edges.

Each output n (1 to 6) works in one of two modes. In single-edge mode it is set by the slot 0 match and cleared by slot n. In double-edge mode (outputs 2 to 6 only) it is set by slot n-1 and cleared by slot n. A double-edge output gives a positive pulse when the set point comes first in the cycle and a negative pulse when the clear point comes first. Since the slots are shared, single-edge and double-edge channels can be mixed freely. Each slot can also stop the timer, restart the counter, or raise a sticky interrupt flag when it matches.

Software writes compare values into holding copies. These copies move into the active set at the period boundary, so a change never cuts a pulse short in the middle of a cycle.

Top module: `mpwm`

## Requirements
- R1: The counter advances by one on each tick, and a tick occurs once every (prescale+1) clocks in which `cnt_en` is high while the timer runs. With `cnt_en` low, or with the timer halted, the count and the prescale phase hold.
- R2: A tick that processes a count equal to active slot 0 returns the counter to 0 on that clock edge, so the period is slot0+1 ticks. Every output change takes effect on the same edge at which the counter leaves the matching value.
- R3: A single-edge output goes high when slot 0 matches and goes low when its own slot matches. If its slot equals slot 0, it stays low. If its slot is greater than slot 0, it stays high.
- R4: Setting mode bit n (n = 2 to 6) at address 10 makes output n double-edge: slot n-1 sets it and slot n clears it. This gives a positive pulse when slot n-1 < slot n and a negative pulse when slot n < slot n-1. Mode bits 0 and 1 have no effect, so output 1 is always single-edge.
- R5: When a set and a clear reach the same output on the same tick, the clear wins. A double-edge output with equal set and clear slots therefore stays low.
- R6: A write to slot i (address i, 0 to 6) while the timer runs changes only the holding copy. The active value takes it at the next slot 0 match. While the timer is halted, the active values follow the holding copies.
- R7: Bit i of the restart mask (address 8) makes a slot i match return the counter to 0.
- R8: Bit i of the halt mask (address 9) makes a slot i match clear the run state and keep the counter at the matched value. If slot 0 matches on the same tick, the counter still goes to 0 and the timer still halts.
- R9: Bit i of the interrupt mask (address 7) makes a slot i match set flag i. Flags stay set until 1 is written to their bit at address 13. Bits written as 0 are left unchanged. `irq_o` is the OR of all flags.
- R10: Address 12 controls the timer: bit 0 is the run state and bit 1 zeroes the counter and the prescale phase. Address 11 holds the prescale value. After reset the counter, outputs, flags and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Clock enable for the prescaler and counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | CW (16) | Write data |
| pwm_o | output | NCH (6) | PWM outputs; bit n-1 is output n |
| irq_flags_o | output | NCH+1 (7) | Sticky match flags, one per slot |
| irq_o | output | 1 | OR of all flags |
| count_o | output | CW (16) | Current counter value |
| running_o | output | 1 | Run state |

## Verification
The bench checks every output against a level model, tick by tick, over mixed configurations. These include an output whose clear slot equals the period (a design that let set win would emit one-tick glitches). They also include a slot above the period (it must stay high) and a clear-before-set pair that must give a negative pulse. A compare value is rewritten in the middle of a cycle. A design without holding copies would move that edge within the same period. The bench fires a halt on the same tick as the slot 0 wrap, where the wrong priority leaves the counter at the period value instead of 0. It also clears one of two flags to show that the other flag survives.

// File: rtl/mpwm.sv
module mpwm #(
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CW-1:0]    wr_data,
  output logic [NCH-1:0]   pwm_o,
  output logic [NCH:0]     irq_flags_o,
  output logic             irq_o,
  output logic [CW-1:0]    count_o,
  output logic             running_o
);
  localparam int NMR    = NCH + 1;
  localparam int SEL_W  = 2 ** AW;
  localparam int A_IEN  = NMR;
  localparam int A_RST  = NMR + 1;
  localparam int A_STOP = NMR + 2;
  localparam int A_MODE = NMR + 3;
  localparam int A_PSC  = NMR + 4;
  localparam int A_CTL  = NMR + 5;
  localparam int A_CLR  = NMR + 6;

  logic [CW-1:0]     mr_sh [NMR];
  logic [CW-1:0]     mr    [NMR];
  logic [NMR*CW-1:0] mr_flat;
  logic [NMR-1:0]    ien, rst_on, stop_on, match, flags;
  logic [NCH:2]      dbl;
  logic [PW-1:0]     psc, pc;
  logic [CW-1:0]     count;
  logic              run;
  logic [NCH-1:0]    pwm_q;
  logic [SEL_W-1:0]  sel;
  logic              tick, clr_cnt, do_rst, do_stop;

  assign sel     = wr_en ? (SEL_W'(1) << wr_addr) : '0;
  assign tick    = run && cnt_en && (pc == psc);
  assign clr_cnt = sel[A_CTL] && wr_data[1];
  assign do_rst  = match[0] || (|(match & rst_on));
  assign do_stop = |(match & stop_on);

  for (genvar i = 0; i < NMR; i++) begin : g_slot
    assign match[i] = tick && (count == mr[i]);
    assign mr_flat[i*CW +: CW] = mr[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      mr_sh[i] <= '0;
      else if (sel[i]) mr_sh[i] <= wr_data;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 mr[i] <= '0;
      else if (!run || match[0])  mr[i] <= mr_sh[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien     <= '0;
      rst_on  <= '0;
      stop_on <= '0;
      dbl     <= '0;
      psc     <= '0;
    end else begin
      if (sel[A_IEN])  ien     <= wr_data[NMR-1:0];
      if (sel[A_RST])  rst_on  <= wr_data[NMR-1:0];
      if (sel[A_STOP]) stop_on <= wr_data[NMR-1:0];
      if (sel[A_MODE]) dbl     <= wr_data[NCH:2];
      if (sel[A_PSC])  psc     <= wr_data[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      count <= '0;
      pc    <= '0;
    end else begin
      if (sel[A_CTL])  run <= wr_data[0];
      else if (do_stop) run <= 1'b0;
      if (clr_cnt) begin
        count <= '0;
        pc    <= '0;
      end else if (run && cnt_en) begin
        pc <= tick ? '0 : pc + 1'b1;
        if (tick) count <= do_rst ? '0 : (do_stop ? count : count + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~(sel[A_CLR] ? wr_data[NMR-1:0] : '0)) | (match & ien);

  for (genvar n = 1; n <= NCH; n++) begin : g_out
    logic set_w;
    if (n >= 2) begin : g_dual
      assign set_w = dbl[n] ? match[n-1] : match[0];
    end else begin : g_single
      assign set_w = match[0];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        pwm_q[n-1] <= 1'b0;
      else if (match[n]) pwm_q[n-1] <= 1'b0;
      else if (set_w)    pwm_q[n-1] <= 1'b1;
  end

  assign pwm_o       = pwm_q;
  assign irq_flags_o = flags;
  assign irq_o       = |flags;
  assign count_o     = count;
  assign running_o   = run;
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk #(
  parameter int CW  = 16,
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic [NCH:0]        match,
  input logic [NCH:0]        stop_on,
  input logic [CW-1:0]       count,
  input logic [NCH-1:0]      pwm,
  input logic                run,
  input logic [NCH:0]        flags,
  input logic                wr_en,
  input logic [AW-1:0]       wr_addr,
  input logic [CW-1:0]       wr_data,
  input logic [(NCH+1)*CW-1:0] mr_flat
);
  localparam int A_CTL = NCH + 6;
  localparam int A_CLR = NCH + 7;

  logic clr_wr, ctl_wr, w1c_wr;
  assign ctl_wr = wr_en && (wr_addr == AW'(A_CTL));
  assign clr_wr = ctl_wr && wr_data[1];
  assign w1c_wr = wr_en && (wr_addr == AW'(A_CLR));

  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (match[0] && !clr_wr) |=> (count == '0)); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_wr) |=> $stable(count)); // R1

  AST_HALT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(match & stop_on)) && !ctl_wr) |=> !run); // R8

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !match[0]) |=> $stable(mr_flat)); // R6

  for (genvar n = 1; n <= NCH; n++) begin : g_clr
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      match[n] |=> !pwm[n-1]); // R5
  end

  for (genvar i = 0; i <= NCH; i++) begin : g_flag
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(w1c_wr && wr_data[i])) |=> flags[i]); // R9
  end
endmodule

bind mpwm mpwm_chk #(.CW(CW), .NCH(NCH), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .match(match), .stop_on(stop_on),
  .count(count), .pwm(pwm_q), .run(run), .flags(flags), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .mr_flat(mr_flat)
);

// File: tb/test_mpwm.sv
`timescale 1ns/1ps
module test_mpwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  pwm_o;
  logic [6:0]  irq_flags_o;
  logic        irq_o;
  logic [15:0] count_o;
  logic        running_o;

  mpwm i_mpwm (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o), .irq_flags_o(irq_flags_o),
    .irq_o(irq_o), .count_o(count_o), .running_o(running_o));

  always #2 clk = ~clk;

  // period, slot1..slot6, mode bits
  localparam int VEC [3][8] = '{
    '{9,  3, 5, 9, 12, 0, 7, 0},
    '{11, 4, 2, 8, 10, 3, 6, 104},
    '{7,  4, 4, 1, 6,  5, 7, 22}
  };

  int checks = 0;
  int errors = 0;
  int cur_m [7];
  int pend  [7];
  int cur_mode;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [5:0] exp_pwm(int c);
    logic [5:0] r;
    for (int n = 1; n <= 6; n++) begin
      int m, s, f;
      m = cur_m[n];
      if (n >= 2 && cur_mode[n]) begin
        s = cur_m[n-1]; f = m;
        if (s == f)     r[n-1] = 1'b0;
        else if (s < f) r[n-1] = (c >= s) && (c < f);
        else            r[n-1] = !((c >= f) && (c < s));
      end else begin
        if (m == cur_m[0]) r[n-1] = 1'b0;
        else               r[n-1] = (c == cur_m[0]) || (c < m);
      end
    end
    return r;
  endfunction

  task automatic run_chk(string tag, int n, int skip, int wa, int wi, int wv);
    for (int k = 0; k < n; k++) begin
      int c;
      c = count_o;
      if (k == wa) begin wr_en = 1'b1; wr_addr = 4'(wi); wr_data = 16'(wv); end
      @(negedge clk);
      wr_en = 1'b0;
      if (k >= skip) begin
        chk({tag, " count"}, count_o, (c == cur_m[0]) ? 0 : c + 1);
        chk({tag, " pwm"}, pwm_o, exp_pwm(c));
      end
      if (c == cur_m[0]) for (int i = 0; i < 7; i++) cur_m[i] = pend[i];
      if (k == wa) pend[wi] = wv;
    end
  endtask

  task automatic cfg_vec(int v);
    wr(12, 0);
    for (int i = 0; i < 7; i++) begin
      wr(i, VEC[v][i]);
      cur_m[i] = VEC[v][i];
      pend[i]  = VEC[v][i];
    end
    wr(7, 0); wr(8, 0); wr(9, 0); wr(11, 0);
    wr(10, VEC[v][7]);
    cur_mode = VEC[v][7];
    wr(12, 3);
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R10 actual hung expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset count", count_o, 0);
    chk("R10 reset pwm", pwm_o, 0);
    chk("R10 reset flags", irq_flags_o, 0);
    chk("R10 reset irq", irq_o, 0);
    chk("R10 reset run", running_o, 0);

    // R1 prescaler and enable gating
    wr(0, 100); wr(11, 2); wr(12, 3);
    ticks(2); chk("R1 prescale hold", count_o, 0);
    ticks(1); chk("R1 prescale first tick", count_o, 1);
    ticks(3); chk("R1 prescale second tick", count_o, 2);
    cnt_en = 1'b0;
    ticks(5); chk("R1 enable low hold", count_o, 2);
    cnt_en = 1'b1;
    ticks(3); chk("R1 enable resume", count_o, 3);

    // table of mixed configurations: R2 R3 R4 R5
    for (int v = 0; v < 3; v++) begin
      cfg_vec(v);
      run_chk("R2 R3 R4 R5 vec", 3 * (VEC[v][0] + 1), VEC[v][0] + 1, -1, 0, 0);
    end

    // R6 mid-cycle rewrite of slot 1 waits for the period boundary
    cfg_vec(0);
    run_chk("R6 shadow", 40, 10, 14, 1, 6);

    // R7 restart on slot 2
    wr(12, 0); wr(0, 50); wr(2, 3); wr(8, 4); wr(12, 3);
    ticks(3); chk("R7 before restart", count_o, 3);
    ticks(1); chk("R7 restart to zero", count_o, 0);
    wr(8, 0);

    // R8 halt on slot 3
    wr(12, 0); wr(0, 50); wr(3, 5); wr(9, 8); wr(7, 8); wr(13, 127); wr(12, 3);
    ticks(6);
    chk("R8 halt count", count_o, 5);
    chk("R8 halt run", running_o, 0);
    ticks(4); chk("R8 halt stays", count_o, 5);
    chk("R9 flag from slot 3", irq_flags_o, 8);
    chk("R9 irq out", irq_o, 1);

    // R8 halt on slot 0: wrap still wins
    wr(12, 0); wr(0, 4); wr(9, 1); wr(7, 0); wr(12, 3);
    ticks(5);
    chk("R8 wrap beats halt count", count_o, 0);
    chk("R8 wrap beats halt run", running_o, 0);

    // R9 sticky flags and selective clear
    wr(12, 0); wr(9, 0); wr(0, 5); wr(2, 2); wr(7, 5); wr(13, 127); wr(12, 3);
    ticks(8);
    wr(12, 0);
    chk("R9 flags set", irq_flags_o, 5);
    wr(13, 4);
    chk("R9 partial clear", irq_flags_o, 1);
    chk("R9 irq still high", irq_o, 1);
    wr(13, 1);
    chk("R9 all clear", irq_flags_o, 0);
    chk("R9 irq low", irq_o, 0);

    finish_up();
  end
endmodule